// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch-stage status of every hardware thread in a multithreaded core and moves each one between nine states every cycle. The inputs are the stall and release pulses from the four downstream pipeline stages, squash requests from the commit and decode stages, a reorder-buffer-still-squashing level from commit, a global context-switch level, and the events that the fetch datapath and the instruction cache raise: a miss is sent, a miss is refused, a refused miss may retry, a fill comes back, and a fetch slot consumes a completed fill. The datapath also reports trap and quiesce events.

Every thread is updated in parallel. A thread's next status comes from a fixed priority chain. A squash from commit is at the top. Below it come the reorder-buffer squash, the decode squash, the stall check and the return to Running, in that order. Cache and datapath events come last. The stall check leaves a thread that is waiting on the cache in its wait state. The outputs are the per-thread status codes, a per-thread flag that marks a cycle in which a control rule fired, and one flag that says whether the fetch stage has any work.

Top module: `thread_fetch_status`

## Requirements
- R1: Each thread keeps one sticky stall flag for each of its four stages. Stage index 0 is decode, 1 rename, 2 execute and 3 commit, and the input bit is `thread*4 + stage`. A set pulse raises the flag. A later clear pulse lowers it. Flags update before the status decision of the same cycle. A clear pulse is legal only while its flag is raised and its set pulse is low.
- R2: A thread is stalled while the context-switch level is high or any of its four flags is raised. An active thread that is stalled and not in WaitResponse or WaitRetry moves to Blocked and raises its changed flag.
- R3: A commit squash for a thread forces Squashing and raises the changed flag, whatever else arrives in that cycle.
- R4: When there is no commit squash, a raised reorder-buffer-squashing level keeps the thread in Squashing and raises the changed flag every cycle the level is high.
- R5: A decode squash moves a thread to Squashing and raises the changed flag only when the thread is not already in Squashing. In Squashing the decode squash is ignored.
- R6: A stall never moves a thread out of WaitResponse (code 4) or WaitRetry (code 5).
- R7: A thread in Blocked or Squashing that sees no squash and no stall returns to Running and raises the changed flag. In every other case the changed flag is low.
- R8: A fill for a thread in WaitResponse moves it to Blocked if the thread is stalled and to AccessComplete (code 6) otherwise. A fetch slot turns AccessComplete into Running. A fill in any other state has no effect.
- R9: From Running, a miss sent moves the thread to WaitResponse and a refused miss moves it to WaitRetry. A retry grant moves WaitRetry to WaitResponse.
- R10: From Running, a trap event moves the thread to TrapPending (code 7) and a quiesce event moves it to QuiescePending (code 8). A wake event returns either of these states to Running.
- R11: A thread whose active input is low goes to Idle (code 1) and returns to Running when it is active again. The stage-active output is high exactly when some thread is in Running, Squashing or AccessComplete.
- R12: Each status is a 4-bit code: Running 0, Idle 1, Squashing 2, Blocked 3, WaitResponse 4, WaitRetry 5, AccessComplete 6, TrapPending 7, QuiescePending 8. Thread t sits in bits `4t+3:4t`. While reset is high, every thread is Running, every flag is clear, every changed flag is low and stage-active is high. All outputs are registered and reflect the decision one clock after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_active_i | input | NUM_THREADS | Thread takes part in fetch |
| stall_set_i | input | NUM_THREADS*4 | Stall pulse, bit thread*4+stage |
| stall_clr_i | input | NUM_THREADS*4 | Release pulse, bit thread*4+stage |
| ctx_switch_i | input | 1 | Context switch pending (stalls every thread) |
| commit_squash_i | input | NUM_THREADS | Squash request from commit |
| rob_squashing_i | input | NUM_THREADS | Reorder buffer still squashing |
| decode_squash_i | input | NUM_THREADS | Squash request from decode |
| miss_issue_i | input | NUM_THREADS | Cache miss sent, wait for response |
| miss_reject_i | input | NUM_THREADS | Cache miss refused, wait for retry |
| retry_ok_i | input | NUM_THREADS | Refused miss resent |
| fill_done_i | input | NUM_THREADS | Cache fill returned |
| fetch_slot_i | input | NUM_THREADS | Fetch consumes a completed fill |
| trap_i | input | NUM_THREADS | Trap pending event |
| quiesce_i | input | NUM_THREADS | Quiesce pending event |
| wake_i | input | NUM_THREADS | Leave trap or quiesce wait |
| status_o | output | NUM_THREADS*4 | Per-thread status codes |
| changed_o | output | NUM_THREADS | A control rule fired for the thread |
| stage_active_o | output | 1 | Fetch stage has work |

## Verification
The bench drives the stall flags in overlapping patterns: two stages raised and released in turn, the context switch alone, and a commit squash in the same cycle as a commit stall. These patterns separate a per-stage sticky flag from a shared one, and show whether the flags update before the decision. Squash sequences cover a repeated decode squash, first in Squashing and then out of it, and a reorder-buffer level held for two cycles, so the conditional decode rule and the two commit sources can be told apart. Cache sequences first stall a thread inside both wait states and then complete the fill with and without a stall, and a fill is also sent into a squashed wait. All threads are parked in waits at once, and separately with one thread inactive, to check that stage-active ignores waiting and idle threads.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int FS_W = 4;

  typedef enum logic [FS_W-1:0] {
    FS_RUNNING    = 4'd0,
    FS_IDLE       = 4'd1,
    FS_SQUASHING  = 4'd2,
    FS_BLOCKED    = 4'd3,
    FS_WAIT_RESP  = 4'd4,
    FS_WAIT_RETRY = 4'd5,
    FS_ACC_DONE   = 4'd6,
    FS_TRAP_PEND  = 4'd7,
    FS_QUIES_PEND = 4'd8
  } fstat_e;

  typedef struct packed {
    logic commit_sq;
    logic rob_sq;
    logic dec_sq;
    logic miss_issue;
    logic miss_reject;
    logic retry_ok;
    logic fill;
    logic slot;
    logic trap;
    logic quiesce;
    logic wake;
  } thr_ev_t;

  function automatic logic fs_is_busy(fstat_e s);
    return (s == FS_RUNNING) || (s == FS_SQUASHING) || (s == FS_ACC_DONE);
  endfunction
endpackage

// File: rtl/fsp_stall_flags.sv
module fsp_stall_flags #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_STAGES  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_THREADS*NUM_STAGES-1:0] set_i,
  input  logic [NUM_THREADS*NUM_STAGES-1:0] clr_i,
  input  logic                          ctx_i,
  output logic [NUM_THREADS*NUM_STAGES-1:0] flags_q,
  output logic [NUM_THREADS-1:0]        stalled_o
);
  localparam int NBITS = NUM_THREADS * NUM_STAGES;

  logic [NBITS-1:0] flags_d;

  // Pulses of this cycle are folded in before the decision sees them.
  assign flags_d = (flags_q | set_i) & ~clr_i;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign stalled_o[t] = ctx_i | (|flags_d[t*NUM_STAGES +: NUM_STAGES]);
  end
endmodule

// File: rtl/fsp_thread_next.sv
module fsp_thread_next
  import fsp_pkg::*;
(
  input  fstat_e  cur_i,
  input  logic    active_i,
  input  logic    stalled_i,
  input  thr_ev_t ev_i,
  output fstat_e  nxt_o,
  output logic    chg_o
);
  always_comb begin
    nxt_o = cur_i;
    chg_o = 1'b0;
    if (!active_i) begin
      nxt_o = FS_IDLE;
    end else if (cur_i == FS_IDLE) begin
      nxt_o = FS_RUNNING;
    end else if (ev_i.commit_sq) begin
      nxt_o = FS_SQUASHING;
      chg_o = 1'b1;
    end else if (ev_i.rob_sq) begin
      nxt_o = FS_SQUASHING;
      chg_o = 1'b1;
    end else if (ev_i.dec_sq && cur_i != FS_SQUASHING) begin
      nxt_o = FS_SQUASHING;
      chg_o = 1'b1;
    end else if (stalled_i && cur_i != FS_WAIT_RESP && cur_i != FS_WAIT_RETRY) begin
      nxt_o = FS_BLOCKED;
      chg_o = 1'b1;
    end else if (cur_i == FS_BLOCKED || cur_i == FS_SQUASHING) begin
      nxt_o = FS_RUNNING;
      chg_o = 1'b1;
    end else begin
      unique case (cur_i)
        FS_RUNNING: begin
          if (ev_i.trap)             nxt_o = FS_TRAP_PEND;
          else if (ev_i.quiesce)     nxt_o = FS_QUIES_PEND;
          else if (ev_i.miss_issue)  nxt_o = FS_WAIT_RESP;
          else if (ev_i.miss_reject) nxt_o = FS_WAIT_RETRY;
        end
        FS_WAIT_RESP:  if (ev_i.fill)     nxt_o = stalled_i ? FS_BLOCKED : FS_ACC_DONE;
        FS_WAIT_RETRY: if (ev_i.retry_ok) nxt_o = FS_WAIT_RESP;
        FS_ACC_DONE:   if (ev_i.slot)     nxt_o = FS_RUNNING;
        FS_TRAP_PEND,
        FS_QUIES_PEND: if (ev_i.wake)     nxt_o = FS_RUNNING;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fsp_activity.sv
module fsp_activity
  import fsp_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS*FS_W-1:0] nxt_i,
  output logic                        busy_o
);
  logic [NUM_THREADS-1:0] busy_vec;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign busy_vec[t] = fs_is_busy(fstat_e'(nxt_i[t*FS_W +: FS_W]));
  end

  assign busy_o = |busy_vec;
endmodule

// File: rtl/thread_fetch_status.sv
module thread_fetch_status
  import fsp_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_STAGES  = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_THREADS-1:0]            thread_active_i,
  input  logic [NUM_THREADS*NUM_STAGES-1:0] stall_set_i,
  input  logic [NUM_THREADS*NUM_STAGES-1:0] stall_clr_i,
  input  logic                              ctx_switch_i,
  input  logic [NUM_THREADS-1:0]            commit_squash_i,
  input  logic [NUM_THREADS-1:0]            rob_squashing_i,
  input  logic [NUM_THREADS-1:0]            decode_squash_i,
  input  logic [NUM_THREADS-1:0]            miss_issue_i,
  input  logic [NUM_THREADS-1:0]            miss_reject_i,
  input  logic [NUM_THREADS-1:0]            retry_ok_i,
  input  logic [NUM_THREADS-1:0]            fill_done_i,
  input  logic [NUM_THREADS-1:0]            fetch_slot_i,
  input  logic [NUM_THREADS-1:0]            trap_i,
  input  logic [NUM_THREADS-1:0]            quiesce_i,
  input  logic [NUM_THREADS-1:0]            wake_i,
  output logic [NUM_THREADS*FS_W-1:0]       status_o,
  output logic [NUM_THREADS-1:0]            changed_o,
  output logic                              stage_active_o
);
  localparam int SW = FS_W;

  logic [NUM_THREADS*NUM_STAGES-1:0] stall_flags;
  logic [NUM_THREADS-1:0]            stalled;
  logic [NUM_THREADS*SW-1:0]         status_d;
  logic [NUM_THREADS-1:0]            chg_d;
  logic                              busy_d;

  fsp_stall_flags #(
    .NUM_THREADS(NUM_THREADS),
    .NUM_STAGES (NUM_STAGES)
  ) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_i    (stall_set_i),
    .clr_i    (stall_clr_i),
    .ctx_i    (ctx_switch_i),
    .flags_q  (stall_flags),
    .stalled_o(stalled)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    thr_ev_t ev;
    fstat_e  nxt;

    assign ev.commit_sq   = commit_squash_i[t];
    assign ev.rob_sq      = rob_squashing_i[t];
    assign ev.dec_sq      = decode_squash_i[t];
    assign ev.miss_issue  = miss_issue_i[t];
    assign ev.miss_reject = miss_reject_i[t];
    assign ev.retry_ok    = retry_ok_i[t];
    assign ev.fill        = fill_done_i[t];
    assign ev.slot        = fetch_slot_i[t];
    assign ev.trap        = trap_i[t];
    assign ev.quiesce     = quiesce_i[t];
    assign ev.wake        = wake_i[t];

    fsp_thread_next u_next (
      .cur_i    (fstat_e'(status_o[t*SW +: SW])),
      .active_i (thread_active_i[t]),
      .stalled_i(stalled[t]),
      .ev_i     (ev),
      .nxt_o    (nxt),
      .chg_o    (chg_d[t])
    );

    assign status_d[t*SW +: SW] = nxt;

    always_ff @(posedge clk) begin
      if (rst) begin
        status_o[t*SW +: SW] <= FS_RUNNING;
        changed_o[t]         <= 1'b0;
      end else begin
        status_o[t*SW +: SW] <= status_d[t*SW +: SW];
        changed_o[t]         <= chg_d[t];
      end
    end
  end

  fsp_activity #(.NUM_THREADS(NUM_THREADS)) u_act (
    .nxt_i (status_d),
    .busy_o(busy_d)
  );

  always_ff @(posedge clk) begin
    if (rst) stage_active_o <= 1'b1;
    else     stage_active_o <= busy_d;
  end
endmodule

// File: rtl/thread_fetch_status_chk.sv
module thread_fetch_status_chk
  import fsp_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_STAGES  = 4
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NUM_THREADS-1:0]            thread_active_i,
  input logic [NUM_THREADS*NUM_STAGES-1:0] stall_set_i,
  input logic [NUM_THREADS*NUM_STAGES-1:0] stall_clr_i,
  input logic [NUM_THREADS*NUM_STAGES-1:0] stall_flags,
  input logic [NUM_THREADS-1:0]            stalled,
  input logic [NUM_THREADS-1:0]            commit_squash_i,
  input logic [NUM_THREADS-1:0]            rob_squashing_i,
  input logic [NUM_THREADS-1:0]            decode_squash_i,
  input logic [NUM_THREADS-1:0]            fill_done_i,
  input logic [NUM_THREADS*FS_W-1:0]       status_o,
  input logic [NUM_THREADS-1:0]            changed_o,
  input logic                              stage_active_o
);
  logic [NUM_THREADS-1:0] busy_now;

  for (genvar b = 0; b < NUM_THREADS*NUM_STAGES; b++) begin : g_bit
    AST_UNBLOCK_LEGAL: assert property (@(posedge clk) disable iff (rst)
      stall_clr_i[b] |-> (stall_flags[b] && !stall_set_i[b])); // R1
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [FS_W-1:0] st;
    assign st = status_o[t*FS_W +: FS_W];
    assign busy_now[t] = (st == FS_RUNNING) || (st == FS_SQUASHING) || (st == FS_ACC_DONE);

    AST_COMMIT_SQUASH_WINS: assert property (@(posedge clk) disable iff (rst)
      (thread_active_i[t] && st != FS_IDLE && commit_squash_i[t])
      |=> (status_o[t*FS_W +: FS_W] == FS_SQUASHING && changed_o[t])); // R3

    AST_DECODE_SQUASH_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (thread_active_i[t] && st == FS_SQUASHING && !commit_squash_i[t] &&
       !rob_squashing_i[t] && decode_squash_i[t] && !stalled[t])
      |=> (status_o[t*FS_W +: FS_W] == FS_RUNNING)); // R5

    AST_WAIT_SURVIVES_STALL: assert property (@(posedge clk) disable iff (rst)
      (thread_active_i[t] && st == FS_WAIT_RESP && stalled[t] && !fill_done_i[t] &&
       !commit_squash_i[t] && !rob_squashing_i[t] && !decode_squash_i[t])
      |=> (status_o[t*FS_W +: FS_W] == FS_WAIT_RESP)); // R6

    AST_INACTIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !thread_active_i[t] |=> (status_o[t*FS_W +: FS_W] == FS_IDLE)); // R11

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
      st <= FS_QUIES_PEND); // R12
  end

  AST_STAGE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    stage_active_o == (|busy_now)); // R11
endmodule

bind thread_fetch_status thread_fetch_status_chk #(
  .NUM_THREADS(NUM_THREADS),
  .NUM_STAGES (NUM_STAGES)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .thread_active_i(thread_active_i),
  .stall_set_i    (stall_set_i),
  .stall_clr_i    (stall_clr_i),
  .stall_flags    (stall_flags),
  .stalled        (stalled),
  .commit_squash_i(commit_squash_i),
  .rob_squashing_i(rob_squashing_i),
  .decode_squash_i(decode_squash_i),
  .fill_done_i    (fill_done_i),
  .status_o       (status_o),
  .changed_o      (changed_o),
  .stage_active_o (stage_active_o)
);

// File: tb/tb_thread_fetch_status.sv
`timescale 1ns/1ps
module tb_thread_fetch_status;
  import fsp_pkg::*;

  localparam int NT = 4;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0]    act = '1;
  logic [NT*NS-1:0] sset = '0, sclr = '0;
  logic             ctx = 1'b0;
  logic [NT-1:0]    csq = '0, rob = '0, dsq = '0, mis = '0, rej = '0, rok = '0;
  logic [NT-1:0]    fil = '0, slt = '0, trp = '0, qui = '0, wak = '0;
  logic [NT*FS_W-1:0] status;
  logic [NT-1:0]      changed;
  logic               stage_active;

  always #2 clk = ~clk;

  thread_fetch_status #(.NUM_THREADS(NT), .NUM_STAGES(NS)) dut (
    .clk(clk), .rst(rst), .thread_active_i(act),
    .stall_set_i(sset), .stall_clr_i(sclr), .ctx_switch_i(ctx),
    .commit_squash_i(csq), .rob_squashing_i(rob), .decode_squash_i(dsq),
    .miss_issue_i(mis), .miss_reject_i(rej), .retry_ok_i(rok),
    .fill_done_i(fil), .fetch_slot_i(slt), .trap_i(trp), .quiesce_i(qui),
    .wake_i(wak), .status_o(status), .changed_o(changed),
    .stage_active_o(stage_active)
  );

  typedef struct {
    int     tid;
    int     st;
    int     chg;
    int     sact;
    string  tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic expect_thr(int tid, fstat_e st, int chg, int sact, string tag);
    exp_t e;
    e.tid = tid; e.st = int'(st); e.chg = chg; e.sact = sact; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: results of the edge are sampled 1 ns after it.
  always @(posedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      int got;
      e = exp_q.pop_front();
      got = int'(status[e.tid*FS_W +: FS_W]);
      checks++;
      if (got != e.st) begin
        errors++;
        $display("FAIL %s: thread %0d status %0d expected %0d", e.tag, e.tid, got, e.st);
      end
      if (e.chg >= 0) begin
        checks++;
        if (int'(changed[e.tid]) != e.chg) begin
          errors++;
          $display("FAIL %s: thread %0d changed %0d expected %0d", e.tag, e.tid, changed[e.tid], e.chg);
        end
      end
      if (e.sact >= 0) begin
        checks++;
        if (int'(stage_active) != e.sact) begin
          errors++;
          $display("FAIL %s: stage_active %0d expected %0d", e.tag, stage_active, e.sact);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    sset = '0; sclr = '0; csq = '0; rob = '0; dsq = '0; mis = '0; rej = '0;
    rok = '0; fil = '0; slt = '0; trp = '0; qui = '0; wak = '0;
  endtask

  task automatic blk(int t, int s); sset[t*NS+s] = 1'b1; endtask
  task automatic unb(int t, int s); sclr[t*NS+s] = 1'b1; endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int t = 0; t < NT; t++) expect_thr(t, FS_RUNNING, 0, 1, "R12 reset");
    step();
    rst = 1'b0;

    // R1/R2: two sticky stage flags, released in turn
    step(); blk(0, 0); expect_thr(0, FS_BLOCKED, 1, 1, "R2 decode stall");
    step(); blk(0, 1); expect_thr(0, FS_BLOCKED, 1, -1, "R1 rename stall");
    step(); unb(0, 0); expect_thr(0, FS_BLOCKED, 1, -1, "R1 rename flag holds");
    step(); unb(0, 1); expect_thr(0, FS_RUNNING, 1, -1, "R7 release to running");
    step();            expect_thr(0, FS_RUNNING, 0, -1, "R7 quiet cycle");

    // R2: context switch stalls every thread
    step(); ctx = 1'b1;
    for (int t = 0; t < NT; t++) expect_thr(t, FS_BLOCKED, 1, 0, "R2 context switch");
    step(); ctx = 1'b0; expect_thr(0, FS_RUNNING, 1, 1, "R7 after context switch");

    // R3: commit squash beats a same-cycle commit stall
    step(); csq[0] = 1'b1; blk(0, 3); expect_thr(0, FS_SQUASHING, 1, -1, "R3 commit squash");
    step(); expect_thr(0, FS_BLOCKED, 1, -1, "R1 commit flag seen after squash");
    step(); unb(0, 3); expect_thr(0, FS_RUNNING, 1, -1, "R7 commit release");

    // R4: reorder buffer still squashing
    step(); rob[0] = 1'b1; expect_thr(0, FS_SQUASHING, 1, -1, "R4 rob squash 1");
    step(); rob[0] = 1'b1; expect_thr(0, FS_SQUASHING, 1, -1, "R4 rob squash 2");
    step(); expect_thr(0, FS_RUNNING, 1, -1, "R4 rob done");

    // R5: decode squash is conditional
    step(); csq[0] = 1'b1; expect_thr(0, FS_SQUASHING, 1, -1, "R3 squash before decode");
    step(); dsq[0] = 1'b1; expect_thr(0, FS_RUNNING, 1, -1, "R5 decode squash ignored");
    step(); dsq[0] = 1'b1; expect_thr(0, FS_SQUASHING, 1, -1, "R5 decode squash taken");
    step(); expect_thr(0, FS_RUNNING, 1, -1, "R7 after decode squash");

    // R6/R8/R9: wait for response with a stall
    step(); mis[0] = 1'b1; expect_thr(0, FS_WAIT_RESP, 0, -1, "R9 miss sent");
    step(); blk(0, 2); expect_thr(0, FS_WAIT_RESP, 0, -1, "R6 stall in wait response");
    step(); fil[0] = 1'b1; expect_thr(0, FS_BLOCKED, 0, -1, "R8 fill while stalled");
    step(); unb(0, 2); expect_thr(0, FS_RUNNING, 1, -1, "R7 after stalled fill");

    // R6/R8/R9: retry path
    step(); rej[0] = 1'b1; expect_thr(0, FS_WAIT_RETRY, 0, -1, "R9 miss refused");
    step(); blk(0, 0); expect_thr(0, FS_WAIT_RETRY, 0, -1, "R6 stall in wait retry");
    step(); unb(0, 0); expect_thr(0, FS_WAIT_RETRY, 0, -1, "R6 retry holds");
    step(); rok[0] = 1'b1; expect_thr(0, FS_WAIT_RESP, 0, -1, "R9 retry granted");
    step(); fil[0] = 1'b1; expect_thr(0, FS_ACC_DONE, 0, 1, "R8 fill unstalled");
    step(); slt[0] = 1'b1; expect_thr(0, FS_RUNNING, 0, -1, "R8 fetch slot");
    step(); fil[0] = 1'b1; expect_thr(0, FS_RUNNING, 0, -1, "R8 stray fill ignored");

    // R3/R8: fill into a squashed wait
    step(); mis[0] = 1'b1; expect_thr(0, FS_WAIT_RESP, 0, -1, "R9 miss sent again");
    step(); csq[0] = 1'b1; expect_thr(0, FS_SQUASHING, 1, -1, "R3 squash in wait");
    step(); fil[0] = 1'b1; expect_thr(0, FS_RUNNING, 1, -1, "R8 fill after squash ignored");

    // R11: stage activity with every thread waiting
    step(); mis = '1;
    for (int t = 0; t < NT; t++) expect_thr(t, FS_WAIT_RESP, 0, 0, "R11 all waiting");
    step(); fil[2] = 1'b1; expect_thr(2, FS_ACC_DONE, 0, 1, "R11 one fill wakes stage");
    step(); slt[2] = 1'b1; fil[0] = 1'b1; fil[1] = 1'b1; fil[3] = 1'b1;
    expect_thr(2, FS_RUNNING, 0, 1, "R8 slot thread 2");
    expect_thr(3, FS_ACC_DONE, 0, -1, "R8 fill thread 3");
    step(); slt[0] = 1'b1; slt[1] = 1'b1; slt[3] = 1'b1;
    expect_thr(1, FS_RUNNING, 0, 1, "R8 slot thread 1");

    // R10: trap and quiesce
    step(); trp[1] = 1'b1; expect_thr(1, FS_TRAP_PEND, 0, -1, "R10 trap");
    step(); wak[1] = 1'b1; expect_thr(1, FS_RUNNING, 0, -1, "R10 wake from trap");
    step(); qui[1] = 1'b1; expect_thr(1, FS_QUIES_PEND, 0, -1, "R10 quiesce");
    step(); blk(1, 0); expect_thr(1, FS_BLOCKED, 1, -1, "R2 stall in quiesce");
    step(); unb(1, 0); expect_thr(1, FS_RUNNING, 1, -1, "R7 after quiesce stall");

    // R11: inactive thread does not count toward stage activity
    step(); act[3] = 1'b0; mis[0] = 1'b1; mis[1] = 1'b1; mis[2] = 1'b1;
    expect_thr(3, FS_IDLE, 0, 0, "R11 inactive idle");
    step(); act[3] = 1'b1; expect_thr(3, FS_RUNNING, 0, 1, "R11 reactivated");
    expect_thr(0, FS_WAIT_RESP, 0, -1, "R6 wait kept");

    step(); step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule